// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block turns a flat, zero-based bus address into an address inside a device. Four programmable windows do the mapping. Window 0 and windows 2 and 3 cover memory, and window 1 covers registers. Software sets the internal start address of every window. It also sets the length of windows 0, 1 and 2. The windows are stacked back-to-back in bus space in index order, so the bus base of a window is the sum of the lengths of the windows below it. Window 3 has no length setting and runs from its base to the top of the bus space.

A request presents a bus address. One clock later the block returns the translated internal address, the index of the window that claimed it and a miss flag. The miss flag is raised when the translated address runs past the top of the internal address space. Configuration words are written through a small write-only port. A window of length zero claims nothing, and the windows above it move down in bus space by the same amount.

Top module: `win_xlat_top`

## Requirements
- R1: After reset all configuration words are zero and all outputs are low. A request then lands in window 3 (win_idx = 3) with int_addr equal to bus_addr and miss low.
- R2: When cfg_we is high, cfg_sel selects the word to write. cfg_sel[2:1] is the window index. cfg_sel[0] = 0 selects the start address and cfg_sel[0] = 1 selects the length. A request presented in the same cycle as a write uses the old value, and the new value applies from the next cycle.
- R3: Window 0 claims bus addresses 0 to len0-1 and returns start0 + bus_addr.
- R4: Window 1 claims [len0, len0+len1) and window 2 claims [len0+len1, len0+len1+len2). Each returns its start plus the offset from its own bus base.
- R5: Window 3 claims every address at or above len0+len1+len2 and returns start3 plus the offset from that base.
- R6: A window whose length is zero never reports a hit, and the bus ranges of the windows above it move down by the missing length.
- R7: A write with cfg_sel = 7 (the absent length of window 3) changes no translation.
- R8: miss is high when start plus offset exceeds 2^32-1. In that case int_addr holds the low 32 bits of the sum.
- R9: out_valid follows req_valid one cycle later. The other outputs update only on a request and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select {window, is_length} |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| bus_addr | input | 32 | Flat bus address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| int_addr | output | 32 | Translated internal address |
| win_idx | output | 2 | Index of the window that claimed the address |
| miss | output | 1 | Internal address overflow |

## Verification
A corrupted length or a wrong stacked base moves the boundary between two windows. This shows up as the wrong win_idx for addresses next to that boundary, and win_idx is the output of the cycle after the request. A corrupted start word shifts int_addr by a constant amount for every address in that window. A wrong base term gives an offset error that is visible at the first address of the window. For these reasons the checks target the first and last address of every window, layouts that contain a zero-length window, and the overflow at the top of the address space.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;
    localparam int XL_AW   = 32;
    localparam int XL_NWIN = 4;
    localparam int XL_IW   = $clog2(XL_NWIN);
    localparam int XL_SW   = XL_IW + 1;
    localparam int XL_BW   = XL_AW + XL_IW;

    typedef logic [XL_AW-1:0] addr_t;
    typedef logic [XL_BW-1:0] wide_t;
    typedef logic [XL_IW-1:0] widx_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        widx_t idx;
        logic  miss;
    } xl_result_t;

    function automatic logic [XL_SW-1:0] xl_sel_code(input int win, input logic is_len);
        return {widx_t'(win), is_len};
    endfunction

    function automatic wide_t xl_widen(input addr_t a);
        return {{(XL_BW-XL_AW){1'b0}}, a};
    endfunction
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import win_xlat_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [XL_SW-1:0]         cfg_sel,
    input  addr_t                    cfg_wdata,
    output addr_t [XL_NWIN-1:0]      start_q,
    output addr_t [XL_NWIN-2:0]      len_q
);
    for (genvar i = 0; i < XL_NWIN; i++) begin : g_start
        always_ff @(posedge clk) begin
            if (rst)
                start_q[i] <= '0;
            else if (cfg_we && cfg_sel == xl_sel_code(i, 1'b0))
                start_q[i] <= cfg_wdata;
        end
    end

    for (genvar i = 0; i < XL_NWIN-1; i++) begin : g_len
        always_ff @(posedge clk) begin
            if (rst)
                len_q[i] <= '0;
            else if (cfg_we && cfg_sel == xl_sel_code(i, 1'b1))
                len_q[i] <= cfg_wdata;
        end
    end
endmodule

// File: rtl/win_base_calc.sv
module win_base_calc
    import win_xlat_pkg::*;
(
    input  addr_t [XL_NWIN-2:0] len_q,
    output wide_t [XL_NWIN-1:0] base,
    output wide_t [XL_NWIN-2:0] limit
);
    assign base[0] = '0;
    for (genvar i = 0; i < XL_NWIN-1; i++) begin : g_stack
        assign limit[i]  = base[i] + xl_widen(len_q[i]);
        assign base[i+1] = limit[i];
    end
endmodule

// File: rtl/win_xlat_match.sv
module win_xlat_match
    import win_xlat_pkg::*;
(
    input  addr_t                bus_addr,
    input  addr_t [XL_NWIN-1:0]  start_q,
    input  addr_t [XL_NWIN-2:0]  len_q,
    input  wide_t [XL_NWIN-1:0]  base,
    input  wide_t [XL_NWIN-2:0]  limit,
    output widx_t                hit_idx,
    output addr_t                xl_addr,
    output logic                 xl_miss
);
    wide_t              a_w;
    logic [XL_NWIN-1:0] hit;
    addr_t              offset;
    logic [XL_AW:0]     sum;

    assign a_w = xl_widen(bus_addr);

    for (genvar i = 0; i < XL_NWIN; i++) begin : g_hit
        if (i < XL_NWIN-1) begin : g_bounded
            assign hit[i] = (len_q[i] != '0) && (a_w >= base[i]) && (a_w < limit[i]);
        end else begin : g_open
            assign hit[i] = (a_w >= base[i]);
        end
    end

    always_comb begin
        hit_idx = widx_t'(XL_NWIN-1);
        for (int i = XL_NWIN-1; i >= 0; i--) begin
            if (hit[i]) hit_idx = widx_t'(i);
        end
    end

    assign offset  = bus_addr - base[hit_idx][XL_AW-1:0];
    assign sum     = {1'b0, start_q[hit_idx]} + {1'b0, offset};
    assign xl_addr = sum[XL_AW-1:0];
    assign xl_miss = sum[XL_AW];
endmodule

// File: rtl/win_xlat_top.sv
module win_xlat_top
    import win_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       bus_addr,
    output logic              out_valid,
    output logic [31:0]       int_addr,
    output logic [1:0]        win_idx,
    output logic              miss
);
    addr_t [XL_NWIN-1:0] start_q;
    addr_t [XL_NWIN-2:0] len_q;
    wide_t [XL_NWIN-1:0] base;
    wide_t [XL_NWIN-2:0] limit;
    widx_t               hit_idx;
    addr_t               xl_addr;
    logic                xl_miss;
    xl_result_t          res_q;

    win_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_q(start_q), .len_q(len_q)
    );

    win_base_calc u_base (
        .len_q(len_q), .base(base), .limit(limit)
    );

    win_xlat_match u_match (
        .bus_addr(bus_addr), .start_q(start_q), .len_q(len_q),
        .base(base), .limit(limit), .hit_idx(hit_idx),
        .xl_addr(xl_addr), .xl_miss(xl_miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= req_valid;
            if (req_valid) begin
                res_q.addr <= xl_addr;
                res_q.idx  <= hit_idx;
                res_q.miss <= xl_miss;
            end
        end
    end

    assign out_valid = res_q.valid;
    assign int_addr  = res_q.addr;
    assign win_idx   = res_q.idx;
    assign miss      = res_q.miss;
endmodule

// File: rtl/win_xlat_chk.sv
module win_xlat_chk
    import win_xlat_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [31:0]         bus_addr,
    input logic                out_valid,
    input logic [31:0]         int_addr,
    input logic [1:0]          win_idx,
    input addr_t [XL_NWIN-1:0] start_q,
    input addr_t [XL_NWIN-2:0] len_q
);
    logic [XL_AW+1:0] top_base;
    assign top_base = {2'b0, len_q[0]} + {2'b0, len_q[1]} + {2'b0, len_q[2]};

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    a_r3_low_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && len_q[0] != '0 && bus_addr < len_q[0])
        |=> (win_idx == 2'd0) && (int_addr == $past(start_q[0] + bus_addr)));

    a_r6_empty_never_hits: assert property (@(posedge clk) disable iff (rst)
        (req_valid && len_q[0] == '0) |=> (win_idx != 2'd0));

    a_r5_open_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && {2'b0, bus_addr} >= top_base) |=> (win_idx == 2'd3));
endmodule

bind win_xlat_top win_xlat_chk i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .bus_addr(bus_addr),
    .out_valid(out_valid), .int_addr(int_addr), .win_idx(win_idx),
    .start_q(start_q), .len_q(len_q)
);

// File: tb/test_win_xlat_top.sv
module test_win_xlat_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        out_valid;
    logic [31:0] int_addr;
    logic [1:0]  win_idx;
    logic        miss;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    win_xlat_top i_win_xlat_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .bus_addr(bus_addr),
        .out_valid(out_valid), .int_addr(int_addr), .win_idx(win_idx), .miss(miss)
    );

    // {bus_addr, win_idx, int_addr, miss}
    localparam int NV = 9;
    localparam logic [66:0] VEC [NV] = '{
        {32'h0000_0000, 2'd0, 32'h1000_0000, 1'b0},
        {32'h0000_00FF, 2'd0, 32'h1000_00FF, 1'b0},
        {32'h0000_0100, 2'd1, 32'h2000_0000, 1'b0},
        {32'h0000_013F, 2'd1, 32'h2000_003F, 1'b0},
        {32'h0000_0140, 2'd2, 32'h3000_0000, 1'b0},
        {32'h0000_033F, 2'd2, 32'h3000_01FF, 1'b0},
        {32'h0000_0340, 2'd3, 32'h4000_0000, 1'b0},
        {32'h0000_1000, 2'd3, 32'h4000_0CC0, 1'b0},
        {32'hFFFF_FFFF, 2'd3, 32'h3FFF_FCBF, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(input string tag, input logic [31:0] a, input logic [1:0] ei,
                       input logic [31:0] ea, input logic em);
        @(negedge clk);
        req_valid = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " idx"},   64'(win_idx), 64'(ei));
        chk({tag, " addr"},  64'(int_addr), 64'(ea));
        chk({tag, " miss"},  64'(miss), 64'(em));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset addr",  64'(int_addr), 64'd0);
        chk("R1 reset idx",   64'(win_idx), 64'd0);
        req("R1 post-reset", 32'h0000_1234, 2'd3, 32'h0000_1234, 1'b0);

        // R9 idle after a request
        @(posedge clk); #1;
        chk("R9 idle valid", 64'(out_valid), 64'd0);
        chk("R9 hold addr",  64'(int_addr), 64'h1234);

        // R2 encoding: sel = {win, is_len}
        wr(3'd0, 32'h1000_0000); wr(3'd1, 32'h0000_0100);
        wr(3'd2, 32'h2000_0000); wr(3'd3, 32'h0000_0040);
        wr(3'd4, 32'h3000_0000); wr(3'd5, 32'h0000_0200);
        wr(3'd6, 32'h4000_0000);

        // R3 R4 R5 R8 table walk
        for (int i = 0; i < NV; i++) begin
            req($sformatf("R3/R4/R5/R8 vec%0d", i), VEC[i][66:35], VEC[i][34:33],
                VEC[i][32:1], VEC[i][0]);
        end

        // R7 write to absent length of window 3
        wr(3'd7, 32'h0000_0010);
        req("R7 ignored sel7", 32'h0000_1000, 2'd3, 32'h4000_0CC0, 1'b0);
        req("R7 ignored sel7 lo", 32'h0000_0340, 2'd3, 32'h4000_0000, 1'b0);

        // R2 same-cycle write uses old value, next request sees new
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'h5000_0000;
        req_valid = 1'b1; bus_addr = 32'h0000_0340;
        @(posedge clk); #1;
        chk("R2 old start", 64'(int_addr), 64'h4000_0000);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        req("R2 new start", 32'h0000_0340, 2'd3, 32'h5000_0000, 1'b0);

        // R6 zero length window 1: window 2 at 0x100, window 3 at 0x300
        wr(3'd3, 32'h0000_0000);
        req("R6 shift w2 lo", 32'h0000_0100, 2'd2, 32'h3000_0000, 1'b0);
        req("R6 shift w2 hi", 32'h0000_02FF, 2'd2, 32'h3000_01FF, 1'b0);
        req("R6 shift w3",    32'h0000_0300, 2'd3, 32'h5000_0000, 1'b0);
        // R6 zero length window 0
        wr(3'd1, 32'h0000_0000);
        req("R6 empty w0", 32'h0000_0000, 2'd2, 32'h3000_0000, 1'b0);

        // R8 overflow inside window 0
        wr(3'd1, 32'h0000_0100); wr(3'd0, 32'hFFFF_FFF0);
        req("R8 no miss edge", 32'h0000_000F, 2'd0, 32'hFFFF_FFFF, 1'b0);
        req("R8 miss",         32'h0000_0010, 2'd0, 32'h0000_0000, 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule